// File: doc/BRIEF.md
# Serial Per-Channel Tristate Control Generator

This block drives four serial control lines that tell external output buffers, one channel at a time, whether each of sixteen backplane output streams should drive or float. Every stream has 512 channels per frame. Each control line runs at one bit per 16.384 MHz clock enable and is shared by four streams. A frame has 2048 control periods per line, which is four streams times 512 channels.

A host write port stores one control bit for each stream and channel. A free-running period counter is aligned by a frame pulse. The counter picks, in every period, one channel and one stream slot. The four storage banks are read in parallel, one bank for each line, and the four bits are registered onto the outputs. The whole sequence is advanced ahead of the frame boundary, so that each bit reaches the buffer before the channel it controls.

Top module: `tsc_gen_top`

## Requirements
- R1: After reset, and until the first frame pulse sampled with the clock enable high, all four outputs are 0.
- R2: A frame pulse sampled with the enable high numbers the period that begins at that enable as 1. Each later enable adds one, modulo 2048, so the last period before the next boundary is 2048, which is 0.
- R3: The bit for channel 0 of stream k (k = 0..3) goes out on line k in period 2043. The bit for channel 0 of stream k+12 goes out on line k in period 2046.
- R4: The bit for channel n of stream k+4j goes out on line k in period (2043 + 4n + j) mod 2048. Two examples: stream 4, channel 510 is in period 2036 on line 0, and stream 5, channel 4 is in period 12 on line 1.
- R5: Line k carries only streams k, k+4, k+8 and k+12. On consecutive periods of one channel, the streams come in that order. The line is the stream number mod 4, and the slot is the stream number div 4.
- R6: The outputs are registered and change only on clocks with the enable high. An output of 1 means the channel is driven and 0 means it is tristated, exactly as the stored bit.
- R7: A frame pulse on a clock with the enable low is ignored.
- R8: A write with wr_en high stores wr_bit for (wr_stream, wr_chan) at the clock edge. The next time that location is scheduled, the new value goes out.
- R9: A write in the same clock that reads the same location puts the old value on the output. The new value goes out in the next frame.
- R10: A frame pulse in the middle of a frame realigns the counter at once, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce16 | input | 1 | 16.384 MHz period enable |
| frame_p | input | 1 | Frame alignment pulse, qualified by ce16 |
| wr_en | input | 1 | Host write strobe |
| wr_stream | input | 4 | Stream number of the write, 0..15 |
| wr_chan | input | 9 | Channel number of the write, 0..511 |
| wr_bit | input | 1 | Control value to store (1 drive, 0 tristate) |
| ctl_o | output | 4 | Serial control lines, bit k is line k |

## Verification
A host write and the scheduled read of the same storage bit can fall in the same clock. At that point the output must show the bit as it was before the write. The bench provokes this on purpose. It computes which stream and channel the next period will fetch, then writes the complement of that bit on the same enable clock. The scoreboard expects the old value in that period and the new value in the same period of the next frame. A frame pulse driven on a clock without the enable is also mixed into the running sequence, and the bench checks that the output sequence does not move.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int N_LINES     = 4;
  localparam int N_SLOTS     = 4;
  localparam int N_STREAMS   = N_LINES * N_SLOTS;
  localparam int N_CHAN      = 512;
  localparam int N_PERIODS   = N_CHAN * N_SLOTS;
  localparam int FIRST_PER   = N_PERIODS - 5;
  localparam int PER_W       = $clog2(N_PERIODS);
  localparam int CH_W        = $clog2(N_CHAN);
  localparam int SLOT_W      = $clog2(N_SLOTS);
  localparam int LINE_W      = $clog2(N_LINES);
  localparam int STR_W       = $clog2(N_STREAMS);

  // distance of a period from the first scheduled period, modulo a frame
  function automatic logic [PER_W-1:0] sched_offset(input logic [PER_W-1:0] per);
    return per - PER_W'(FIRST_PER);
  endfunction

  function automatic logic [CH_W-1:0] offset_chan(input logic [PER_W-1:0] off);
    return off[PER_W-1:SLOT_W];
  endfunction

  function automatic logic [SLOT_W-1:0] offset_slot(input logic [PER_W-1:0] off);
    return off[SLOT_W-1:0];
  endfunction

  function automatic logic [LINE_W-1:0] stream_line(input logic [STR_W-1:0] s);
    return s[LINE_W-1:0];
  endfunction

  function automatic logic [SLOT_W-1:0] stream_slot(input logic [STR_W-1:0] s);
    return s[STR_W-1:LINE_W];
  endfunction
endpackage

// File: rtl/tsc_period_ctr.sv
module tsc_period_ctr
  import tsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             frame_p,
  output logic             frame_hit,
  output logic [PER_W-1:0] period_nxt,
  output logic [PER_W-1:0] period_q,
  output logic             sync_q
);
  assign frame_hit  = ce && frame_p;
  assign period_nxt = frame_hit ? PER_W'(1) : period_q + PER_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      sync_q   <= 1'b0;
    end else if (ce) begin
      period_q <= period_nxt;
      if (frame_hit) sync_q <= 1'b1;
    end
  end

  p_frame_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && frame_p) |=> (period_q == PER_W'(1)));
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !frame_p) |=> (period_q == $past(period_q) + PER_W'(1)));
  p_no_enable_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(period_q) && $stable(sync_q)));
endmodule

// File: rtl/tsc_ctl_bank.sv
module tsc_ctl_bank
  import tsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_bit,
  input  logic [CH_W-1:0]   rd_chan,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              rd_bit
);
  logic [N_SLOTS-1:0] mem [N_CHAN];

  always_ff @(posedge clk) begin
    if (we) mem[wr_chan][wr_slot] <= wr_bit;
  end

  assign rd_bit = mem[rd_chan][rd_slot];

  p_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(wr_chan)][$past(wr_slot)] == $past(wr_bit)));
endmodule

// File: rtl/tsc_gen_top.sv
module tsc_gen_top
  import tsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce16,
  input  logic             frame_p,
  input  logic             wr_en,
  input  logic [STR_W-1:0] wr_stream,
  input  logic [CH_W-1:0]  wr_chan,
  input  logic             wr_bit,
  output logic [N_LINES-1:0] ctl_o
);
  logic               frame_hit;
  logic [PER_W-1:0]   period_nxt;
  logic [PER_W-1:0]   period_q;
  logic               sync_q;
  logic [PER_W-1:0]   rd_off;
  logic [CH_W-1:0]    rd_chan;
  logic [SLOT_W-1:0]  rd_slot;
  logic [N_LINES-1:0] rd_bits;
  logic [LINE_W-1:0]  wr_line;
  logic [SLOT_W-1:0]  wr_slot;
  logic               rd_wr_clash;
  logic               out_live;

  tsc_period_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .ce(ce16), .frame_p(frame_p),
    .frame_hit(frame_hit), .period_nxt(period_nxt),
    .period_q(period_q), .sync_q(sync_q)
  );

  assign rd_off  = sched_offset(period_nxt);
  assign rd_chan = offset_chan(rd_off);
  assign rd_slot = offset_slot(rd_off);
  assign wr_line = stream_line(wr_stream);
  assign wr_slot = stream_slot(wr_stream);

  for (genvar g = 0; g < N_LINES; g++) begin : g_bank
    tsc_ctl_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && (wr_line == LINE_W'(g))),
      .wr_chan(wr_chan), .wr_slot(wr_slot), .wr_bit(wr_bit),
      .rd_chan(rd_chan), .rd_slot(rd_slot), .rd_bit(rd_bits[g])
    );
  end

  assign out_live    = sync_q || frame_hit;
  assign rd_wr_clash = ce16 && wr_en && out_live &&
                       (wr_chan == rd_chan) && (wr_slot == rd_slot);

  always_ff @(posedge clk) begin
    if (!rst_n)    ctl_o <= '0;
    else if (ce16) ctl_o <= out_live ? rd_bits : '0;
  end

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_q |-> (ctl_o == '0));
  p_out_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ce16 |=> $stable(ctl_o));
  p_clash_old_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_wr_clash && (rd_bits[wr_line] != wr_bit)) |=>
      (ctl_o[$past(wr_line)] != $past(wr_bit)));
endmodule

// File: tb/tb_tsc_gen_top.sv
module tb_tsc_gen_top;
  localparam int CLK_P = 10;
  localparam int NPER  = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce16 = 1'b0, frame_p = 1'b0, wr_en = 1'b0, wr_bit = 1'b0;
  logic [3:0] wr_stream = '0;
  logic [8:0] wr_chan = '0;
  logic [3:0] ctl_o;

  tsc_gen_top dut (
    .clk(clk), .rst_n(rst_n), .ce16(ce16), .frame_p(frame_p),
    .wr_en(wr_en), .wr_stream(wr_stream), .wr_chan(wr_chan),
    .wr_bit(wr_bit), .ctl_o(ctl_o)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct { logic [3:0] v; string tag; int per; } exp_t;
  exp_t sbq[$];

  int checks = 0, fails = 0;
  bit model [16][512];
  int sch_ch [NPER];
  int sch_j  [NPER];
  int bper = 0;
  bit bsync = 0;
  int clash_per = -1;
  int widx = 0;
  logic [3:0] last_exp = '0;
  bit done = 0;

  task automatic report(input bit ok, input string tag, input int per,
                        input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s period %0d: ctl_o=%b expected %b", tag, per, act, exp);
    end
  endtask

  // driver: drives one clock, pushes the expected output of an enabled period
  task automatic tick(input bit c, input bit f, input bit w, input int s,
                      input int ch, input bit b, input string tag);
    exp_t e;
    int np;
    @(negedge clk);
    ce16 = c; frame_p = f; wr_en = w;
    wr_stream = s[3:0]; wr_chan = ch[8:0]; wr_bit = b;
    if (c) begin
      np = f ? 1 : (bper + 1) % NPER;
      if (f) bsync = 1;
      bper = np;
      for (int k = 0; k < 4; k++)
        e.v[k] = bsync ? model[k + 4*sch_j[np]][sch_ch[np]] : 1'b0;
      e.tag = tag;
      if (np == 2036 || np == 12) e.tag = "R4";
      else if (np >= 2043 && np <= 2046) e.tag = "R3";
      else if (np == 1 && f) e.tag = "R2";
      else if (np == clash_per) e.tag = "R9";
      e.per = np;
      sbq.push_back(e);
    end
    if (w) model[s][ch] = b;
  endtask

  function automatic bit pat_a(input int s, input int ch);
    return ((s * 13 + ch * 7 + (s ^ ch)) >> 2) % 2 == 1;
  endfunction

  // n periods, enable every other clock, optional host writes in between
  task automatic run(input int n, input string tag, input bit wr);
    for (int i = 0; i < n; i++) begin
      tick(1, 0, 0, 0, 0, 0, tag);
      if (wr) begin
        tick(0, 0, 1, widx % 16, (widx / 16) % 512,
             ~model[widx % 16][(widx / 16) % 512], tag);
        widx += 37;
      end else tick(0, 0, 0, 0, 0, 0, tag);
    end
  endtask

  // write the complement of the bit that the next enabled period reads
  task automatic clash(input int line);
    int np, n, j, s;
    np = (bper + 1) % NPER;
    n = sch_ch[np]; j = sch_j[np]; s = line + 4*j;
    clash_per = np;
    tick(1, 0, 1, s, n, ~model[s][n], "R9");
    tick(0, 0, 0, 0, 0, 0, "R9");
  endtask

  // monitor: pops the scoreboard after each enabled edge
  initial begin
    exp_t e;
    bit ce_s;
    forever begin
      @(posedge clk);
      ce_s = ce16;
      #1;
      if (rst_n) begin
        if (ce_s) begin
          if (sbq.size() == 0) report(0, "R6", -1, ctl_o, 4'bx);
          else begin
            e = sbq.pop_front();
            report(ctl_o === e.v, e.tag, e.per, ctl_o, e.v);
            last_exp = e.v;
          end
        end else begin
          report(ctl_o === last_exp, "R6", bper, ctl_o, last_exp);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung (actual running, expected finished)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 512; n++)
      for (int j = 0; j < 4; j++) begin
        sch_ch[(2043 + 4*n + j) % NPER] = n;
        sch_j [(2043 + 4*n + j) % NPER] = j;
      end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    report(ctl_o === 4'b0, "R1", 0, ctl_o, 4'b0);
    run(100, "R1", 0);
    for (int s = 0; s < 16; s++)
      for (int ch = 0; ch < 512; ch++)
        tick(0, 0, 1, s, ch, pat_a(s, ch), "R8");
    run(30, "R1", 0);
    tick(1, 1, 0, 0, 0, 0, "R2");
    tick(0, 0, 0, 0, 0, 0, "R2");
    run(NPER, "R5", 0);
    clash(1);
    clash(2);
    run(600, "R5", 0);
    tick(0, 1, 0, 0, 0, 0, "R7");
    run(NPER - 600, "R7", 0);
    clash_per = -1;
    run(700, "R8", 1);
    tick(1, 1, 0, 0, 0, 0, "R10");
    tick(0, 0, 0, 0, 0, 0, "R10");
    run(NPER + 20, "R10", 1);
    tick(0, 0, 0, 0, 0, 0, "R6");
    tick(0, 0, 0, 0, 0, 0, "R6");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule